// File: doc/BRIEF.md
# Translation Table Update Engine

This block maintains a small table of address translation entries that a DMA translation stage consults. A controller hands it one command at a time: write a single entry, read a single entry, fill a run of consecutive entries with one value, or write a run of entries whose values are fetched from a list held in system memory. Each command names an IO bus address, a value or list pointer, and an entry count. The engine answers with a one-cycle completion pulse, a status code and, for a read, the stored entry.

The IO address is first rounded down to a page boundary. It is then turned into a table slot by subtracting the window's bus offset and shifting right by the page size. Multi-entry commands walk forward one page per entry and stop at the first slot that falls outside the table. Every entry that is written produces a one-cycle invalidate notification, so that cached translations for that page can be dropped. List entries are read through a simple request/acknowledge memory port. They are stored most-significant byte first.

Top module: `xlt_table_engine`

## Requirements
- R1: The IO address is rounded down to a page (PAGE_SHIFT low bits cleared). The slot is (address − BUS_OFFSET) >> PAGE_SHIFT, with modular subtraction. A slot of NUM_ENT or more ends the command with status 1 (parameter error) and writes nothing. Status 0 means success.
- R2: Command code 0 writes cmd_arg into the slot. Code 1 reads the slot and, on success, presents the stored 64-bit value unchanged on rd_data.
- R3: A read that fails leaves rd_data at its previous value.
- R4: Code 2 writes cmd_arg into cmd_count consecutive slots, starting at the addressed slot.
- R5: Code 2 with cmd_count greater than NUM_ENT is refused with status 1, writes nothing, and completes one edge after acceptance.
- R6: Code 3 is refused with status 1, with no memory read and no write, when cmd_count exceeds 512 or the list pointer has any of its low 12 bits set. A count of exactly 512 is accepted.
- R7: Code 3 fetches entry i from list pointer + 8·i. The memory port delivers the byte at address +k on bits [8k+7:8k]. The byte at the lowest address is the most significant byte of the entry. Each fetched entry is written to the next slot.
- R8: A multi-entry command stops at the first slot out of range and reports status 1. The entries before that slot stay written.
- R9: One edge after each entry write, ntf_valid is high for one cycle. It carries the page-aligned IO address, the written value with its PAGE_SHIFT low bits cleared, and the value's bits [1:0] as permission.
- R10: Codes 2 and 3 with a count of zero complete with status 0 one edge after acceptance and write nothing.
- R11: busy is high from the accepting edge until the done cycle, and done lasts one cycle. Commands offered while busy is high are ignored. A write or a read completes two edges after acceptance, and a fill of N entries completes N+1 edges after acceptance.
- R12: Reset clears every slot to zero and leaves busy, done and ntf_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered; taken when busy is low |
| cmd_op | input | 2 | 0 write, 1 read, 2 fill, 3 list write |
| cmd_ioba | input | ADDR_W | IO bus address |
| cmd_arg | input | ENT_W | Entry value, or list pointer for code 3 |
| cmd_count | input | CNT_W | Entry count for codes 2 and 3 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 1 | 0 success, 1 parameter error; valid with done |
| rd_data | output | ENT_W | Entry returned by the last successful read |
| mem_req | output | 1 | List read request, held until acknowledged |
| mem_addr | output | ENT_W | Byte address of the list entry |
| mem_ack | input | 1 | Memory returns mem_rdata this cycle |
| mem_rdata | input | ENT_W | List data in address-lane order |
| ntf_valid | output | 1 | Invalidate notification for a written entry |
| ntf_iova | output | ADDR_W | Page-aligned IO address of the written entry |
| ntf_xlat | output | ENT_W | Written value with page-offset bits cleared |
| ntf_perm | output | 2 | Permission bits of the written value |

## Verification
Each command goes through a fixed number of clock edges. The accepting edge comes first. A write or read then takes one more edge. A fill takes one edge per entry. A list entry takes two edges when memory answers at once. A refused or zero-count command is finished after the accepting edge alone. The bench counts rising edges from acceptance until it sees done, at the falling edge, and compares that count with the figure above. It reads status, rd_data and the notification count only after done is visible. The last notification of a command appears in the same cycle as done, so the bench lets a short delay pass before it compares the notification count.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    typedef enum logic [1:0] {
        OP_PUT   = 2'd0,
        OP_GET   = 2'd1,
        OP_STUFF = 2'd2,
        OP_LIST  = 2'd3
    } op_e;

    typedef enum logic {
        ST_OK    = 1'b0,
        ST_PARAM = 1'b1
    } stat_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_STEP,
        S_FETCH,
        S_FIN
    } state_e;

    localparam int unsigned LIST_MAX        = 512;
    localparam int unsigned LIST_ALIGN_BITS = 12;

    // true when a command's fixed argument checks refuse it
    function automatic logic arg_reject(input op_e op, input logic [31:0] count,
                                        input logic [LIST_ALIGN_BITS-1:0] ptr_low,
                                        input logic [31:0] num_ent);
        logic r;
        r = 1'b0;
        if (op == OP_LIST && (count > LIST_MAX || ptr_low != '0)) r = 1'b1;
        if (op == OP_STUFF && count > num_ent) r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/xlt_index_calc.sv
module xlt_index_calc #(
    parameter int ADDR_W = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_ENT = 16,
    parameter logic [ADDR_W-1:0] BUS_OFFSET = '0,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic [ADDR_W-1:0] ioba,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] page;

    always_comb begin
        rel      = ioba - BUS_OFFSET;
        page     = rel >> PAGE_SHIFT;
        in_range = page < ADDR_W'(NUM_ENT);
        idx      = page[IDX_W-1:0];
    end
endmodule

// File: rtl/xlt_entry_ram.sv
module xlt_entry_ram #(
    parameter int NUM_ENT = 16,
    parameter int ENT_W = 64,
    localparam int IDX_W = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] mem [NUM_ENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENT; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/xlt_table_engine.sv
module xlt_table_engine
    import xlt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ENT_W = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int NUM_ENT = 16,
    parameter int CNT_W = 16,
    parameter logic [ADDR_W-1:0] BUS_OFFSET = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_ioba,
    input  logic [ENT_W-1:0]  cmd_arg,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              done,
    output logic              status,
    output logic [ENT_W-1:0]  rd_data,
    output logic              mem_req,
    output logic [ENT_W-1:0]  mem_addr,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              ntf_valid,
    output logic [ADDR_W-1:0] ntf_iova,
    output logic [ENT_W-1:0]  ntf_xlat,
    output logic [1:0]        ntf_perm
);
    localparam int IDX_W = $clog2(NUM_ENT);
    localparam int LANES = ENT_W / 8;
    localparam logic [ADDR_W-1:0] PG_SIZE   = ADDR_W'(1) << PAGE_SHIFT;
    localparam logic [ADDR_W-1:0] PG_MASK_A = ~(PG_SIZE - ADDR_W'(1));
    localparam logic [ENT_W-1:0]  PG_MASK_E = ~((ENT_W'(1) << PAGE_SHIFT) - ENT_W'(1));

    state_e             st;
    op_e                op_q;
    stat_e              stat_q;
    logic [ADDR_W-1:0]  cur_ioba;
    logic [ENT_W-1:0]   arg_q;
    logic [ENT_W-1:0]   wval;
    logic [CNT_W-1:0]   remain;
    logic [CNT_W-1:0]   lidx;
    logic [ENT_W-1:0]   rd_q;

    logic [IDX_W-1:0]   slot;
    logic               slot_ok;
    logic [ENT_W-1:0]   ram_rd;
    logic               we;
    logic [ENT_W-1:0]   list_word;

    op_e                in_op;
    logic               reject;
    logic [CNT_W-1:0]   cnt_eff;

    // list data arrives in address-lane order; lowest address is the MSB
    for (genvar b = 0; b < LANES; b++) begin : g_swap
        assign list_word[8*b +: 8] = mem_rdata[ENT_W-8-8*b +: 8];
    end

    xlt_index_calc #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
        .NUM_ENT(NUM_ENT), .BUS_OFFSET(BUS_OFFSET)
    ) u_idx (
        .ioba(cur_ioba), .idx(slot), .in_range(slot_ok)
    );

    xlt_entry_ram #(.NUM_ENT(NUM_ENT), .ENT_W(ENT_W)) u_ram (
        .clk(clk), .rst(rst), .we(we), .waddr(slot), .wdata(wval),
        .raddr(slot), .rdata(ram_rd)
    );

    always_comb begin
        in_op   = op_e'(cmd_op);
        reject  = arg_reject(in_op, 32'(cmd_count),
                             cmd_arg[LIST_ALIGN_BITS-1:0], 32'(NUM_ENT));
        cnt_eff = (in_op == OP_PUT || in_op == OP_GET) ? CNT_W'(1) : cmd_count;
        we      = (st == S_STEP) && slot_ok && (op_q != OP_GET);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            op_q      <= OP_PUT;
            stat_q    <= ST_OK;
            cur_ioba  <= '0;
            arg_q     <= '0;
            wval      <= '0;
            remain    <= '0;
            lidx      <= '0;
            rd_q      <= '0;
            ntf_valid <= 1'b0;
            ntf_iova  <= '0;
            ntf_xlat  <= '0;
            ntf_perm  <= '0;
        end else begin
            ntf_valid <= 1'b0;
            unique case (st)
                S_IDLE: if (cmd_valid) begin
                    op_q     <= in_op;
                    cur_ioba <= cmd_ioba & PG_MASK_A;
                    arg_q    <= cmd_arg;
                    wval     <= cmd_arg;
                    remain   <= cnt_eff;
                    lidx     <= '0;
                    if (reject) begin
                        stat_q <= ST_PARAM;
                        st     <= S_FIN;
                    end else if (cnt_eff == '0) begin
                        stat_q <= ST_OK;
                        st     <= S_FIN;
                    end else begin
                        st <= (in_op == OP_LIST) ? S_FETCH : S_STEP;
                    end
                end
                S_FETCH: if (mem_ack) begin
                    wval <= list_word;
                    st   <= S_STEP;
                end
                S_STEP: begin
                    if (!slot_ok) begin
                        stat_q <= ST_PARAM;
                        st     <= S_FIN;
                    end else if (op_q == OP_GET) begin
                        rd_q   <= ram_rd;
                        stat_q <= ST_OK;
                        st     <= S_FIN;
                    end else begin
                        ntf_valid <= 1'b1;
                        ntf_iova  <= cur_ioba;
                        ntf_xlat  <= wval & PG_MASK_E;
                        ntf_perm  <= wval[1:0];
                        remain    <= remain - CNT_W'(1);
                        lidx      <= lidx + CNT_W'(1);
                        cur_ioba  <= cur_ioba + PG_SIZE;
                        if (remain == CNT_W'(1)) begin
                            stat_q <= ST_OK;
                            st     <= S_FIN;
                        end else begin
                            st <= (op_q == OP_LIST) ? S_FETCH : S_STEP;
                        end
                    end
                end
                S_FIN: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign busy     = (st != S_IDLE);
    assign done     = (st == S_FIN);
    assign status   = stat_q;
    assign rd_data  = rd_q;
    assign mem_req  = (st == S_FETCH);
    assign mem_addr = arg_q + (ENT_W'(lidx) << 3);

endmodule

// File: rtl/xlt_table_engine_chk.sv
module xlt_table_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int ENT_W = 64,
    parameter int PAGE_SHIFT = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ENT_W-1:0]  mem_addr,
    input logic              ntf_valid,
    input logic [ADDR_W-1:0] ntf_iova,
    input logic [ENT_W-1:0]  ntf_xlat
);
    p_done_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> busy);
    p_ntf_iova_r9: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> (ntf_iova[PAGE_SHIFT-1:0] == '0));
    p_ntf_xlat_r9: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> (ntf_xlat[PAGE_SHIFT-1:0] == '0));
    p_ntf_busy_r9: assert property (@(posedge clk) disable iff (rst)
        ntf_valid |-> busy);
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    p_req_align_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'd0));
    p_req_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
    p_reset_idle_r12: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ntf_valid));
endmodule

bind xlt_table_engine xlt_table_engine_chk #(
    .ADDR_W(ADDR_W), .ENT_W(ENT_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (.*);

// File: tb/sim_xlt_table_engine.sv
module sim_xlt_table_engine;
    localparam logic [31:0] OFS  = 32'h0010_0000;
    localparam logic [63:0] LIST = 64'h0000_3000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_ioba = '0;
    logic [63:0] cmd_arg = '0;
    logic [15:0] cmd_count = '0;
    logic        busy, done, status, mem_req, mem_ack, ntf_valid;
    logic [63:0] rd_data, mem_addr, mem_rdata, ntf_xlat;
    logic [31:0] ntf_iova;
    logic [1:0]  ntf_perm;

    int n_chk = 0, n_fail = 0, ntf_cnt = 0;
    logic [31:0] last_iova;
    logic [63:0] last_xlat;
    logic [1:0]  last_perm;
    int          r_edges;
    logic        r_stat;
    logic [63:0] r_data;

    always #2 clk = ~clk;

    xlt_table_engine u0 (.*);

    function automatic logic [63:0] lword(input int i);
        return 64'h0000_0012_3450_0000 + 64'(i) * 64'h1000 + 64'(i % 4);
    endfunction
    function automatic logic [63:0] swap64(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = v[56-8*b +: 8];
        return r;
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = swap64(lword(int'((mem_addr - LIST) >> 3)));

    always @(negedge clk) if (ntf_valid) begin
        ntf_cnt++;
        last_iova = ntf_iova;
        last_xlat = ntf_xlat;
        last_perm = ntf_perm;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] ioba,
                       input logic [63:0] arg, input logic [15:0] cnt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_ioba = ioba; cmd_arg = arg; cmd_count = cnt;
        @(posedge clk);
        r_edges = 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && r_edges < 200) begin
            @(posedge clk); r_edges++; @(negedge clk);
        end
        #1;
        r_stat = status;
        r_data = rd_data;
    endtask

    function automatic logic [31:0] pg(input int k);
        return OFS + 32'(k) * 32'h1000;
    endfunction

    task automatic t_reset;
        check("R12 busy", 64'(busy), 0);
        check("R12 done", 64'(done), 0);
        check("R12 ntf", 64'(ntf_valid), 0);
        run(2'd1, pg(3), 0, 0);
        check("R12 cleared slot", r_data, 0);
    endtask

    task automatic t_put_get;
        int n0 = ntf_cnt;
        run(2'd0, pg(5) + 32'h123, 64'h0000_0008_7654_3ABF, 0);
        check("R1 put status", 64'(r_stat), 0);
        check("R11 put edges", 64'(r_edges), 2);
        check("R9 ntf count", 64'(ntf_cnt - n0), 1);
        check("R9 ntf iova", 64'(last_iova), 64'(pg(5)));
        check("R9 ntf xlat", last_xlat, 64'h0000_0008_7654_3000);
        check("R9 ntf perm", 64'(last_perm), 3);
        run(2'd1, pg(5) + 32'hFFF, 0, 0);
        check("R2 get status", 64'(r_stat), 0);
        check("R2 get data", r_data, 64'h0000_0008_7654_3ABF);
        check("R11 get edges", 64'(r_edges), 2);
    endtask

    task automatic t_range;
        int n0 = ntf_cnt;
        run(2'd0, pg(16), 64'h5000, 0);
        check("R1 above table", 64'(r_stat), 1);
        run(2'd0, OFS - 32'h1000, 64'h5000, 0);
        check("R1 below offset", 64'(r_stat), 1);
        check("R1 no write ntf", 64'(ntf_cnt - n0), 0);
        run(2'd1, pg(20), 0, 0);
        check("R3 get err status", 64'(r_stat), 1);
        check("R3 rd_data held", r_data, 64'h0000_0008_7654_3ABF);
    endtask

    task automatic t_stuff;
        int n0 = ntf_cnt;
        run(2'd2, pg(8) + 32'h40, 64'h0000_0000_ABCD_E002, 3);
        check("R4 status", 64'(r_stat), 0);
        check("R11 stuff edges", 64'(r_edges), 4);
        check("R4 ntf count", 64'(ntf_cnt - n0), 3);
        check("R9 last iova", 64'(last_iova), 64'(pg(10)));
        for (int k = 8; k < 11; k++) begin
            run(2'd1, pg(k), 0, 0);
            check("R4 filled slot", r_data, 64'h0000_0000_ABCD_E002);
        end
        run(2'd1, pg(11), 0, 0);
        check("R4 next slot untouched", r_data, 0);
    endtask

    task automatic t_stuff_reject;
        int n0 = ntf_cnt;
        run(2'd2, pg(0), 64'h7777_0001, 17);
        check("R5 status", 64'(r_stat), 1);
        check("R5 edges", 64'(r_edges), 1);
        check("R5 no ntf", 64'(ntf_cnt - n0), 0);
        run(2'd1, pg(0), 0, 0);
        check("R5 slot0 untouched", r_data, 0);
    endtask

    task automatic t_partial;
        int n0 = ntf_cnt;
        run(2'd2, pg(14), 64'h0000_0099_0000_0001, 4);
        check("R8 status", 64'(r_stat), 1);
        check("R8 ntf count", 64'(ntf_cnt - n0), 2);
        check("R8 edges", 64'(r_edges), 4);
        run(2'd1, pg(15), 0, 0);
        check("R8 last good slot", r_data, 64'h0000_0099_0000_0001);
    endtask

    task automatic t_zero;
        int n0 = ntf_cnt;
        run(2'd2, pg(1), 64'h1111_1000, 0);
        check("R10 stuff zero status", 64'(r_stat), 0);
        check("R10 stuff zero edges", 64'(r_edges), 1);
        run(2'd3, pg(1), LIST, 0);
        check("R10 list zero status", 64'(r_stat), 0);
        check("R10 no ntf", 64'(ntf_cnt - n0), 0);
        run(2'd1, pg(1), 0, 0);
        check("R10 slot untouched", r_data, 0);
    endtask

    task automatic t_list;
        int n0 = ntf_cnt;
        run(2'd3, pg(1), LIST, 3);
        check("R7 status", 64'(r_stat), 0);
        check("R7 edges", 64'(r_edges), 7);
        check("R7 ntf count", 64'(ntf_cnt - n0), 3);
        check("R9 list perm", 64'(last_perm), 64'(lword(2) & 64'h3));
        for (int k = 0; k < 3; k++) begin
            run(2'd1, pg(1 + k), 0, 0);
            check("R7 list entry", r_data, lword(k));
        end
    endtask

    task automatic t_list_reject;
        int n0 = ntf_cnt;
        run(2'd3, pg(0), LIST, 513);
        check("R6 count 513", 64'(r_stat), 1);
        check("R6 edges", 64'(r_edges), 1);
        run(2'd3, pg(0), LIST + 64'h8, 1);
        check("R6 misaligned list", 64'(r_stat), 1);
        check("R6 no ntf", 64'(ntf_cnt - n0), 0);
        n0 = ntf_cnt;
        run(2'd3, pg(0), LIST, 512);
        check("R6 count 512 taken, R8 stop", 64'(r_stat), 1);
        check("R8 512 ntf", 64'(ntf_cnt - n0), 16);
        check("R8 512 edges", 64'(r_edges), 35);
    endtask

    task automatic t_busy_ignore;
        int n0 = ntf_cnt;
        run(2'd2, pg(12), 0, 1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_ioba = pg(4); cmd_arg = 64'h4444_0003; cmd_count = 3;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 2'd0; cmd_ioba = pg(12); cmd_arg = 64'hDEAD_0001;
        check("R11 busy", 64'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) begin @(posedge clk); @(negedge clk); end
        #1;
        check("R11 ignored ntf", 64'(ntf_cnt - n0), 4);
        run(2'd1, pg(12), 0, 0);
        check("R11 ignored put", r_data, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_put_get();
        t_range();
        t_stuff();
        t_stuff_reject();
        t_partial();
        t_zero();
        t_list();
        t_list_reject();
        t_busy_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule